// File: doc/BRIEF.md
# Composite Video Sync Timing Generator

This block produces the raster timing for a locally timed television picture. It runs from a clock at four times the colour subcarrier. It counts pixel clocks within a line and lines within a frame. From those counts it decodes a separate horizontal sync pulse, a separate vertical sync pulse and a composite sync. The composite sync carries half-line equalizing pulses and serrated broad pulses around each vertical sync. The block also drives an active-low vertical blanking flag and a horizontal blanking flag. It exposes the live line and pixel numbers so that character or graphics logic downstream can place its output.

A two-bit input selects the 525-line or 625-line standard and the line length. A second input selects an interlaced frame or a progressive one. In the interlaced frame the second field's vertical interval starts half a line late. In the progressive frame each field is a whole number of lines. Both selects are taken only when the frame wraps, so a frame is never cut short or stretched by a change in mid-picture. A synchronous reset starts the raster at line 1, pixel 0.

Top module: `video_sync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the counters load line 1 and pixel 0, and the standard and interlace selects are taken from the inputs.
- R2: A line lasts NTSC_CLKS clocks for `stdSel` 0 or 3, PAL_CLKS for `stdSel` 1 and PALM_CLKS for `stdSel` 2. The pixel number counts 0 up to the line length minus 1 and then returns to 0.
- R3: In the 625-line standard, the last line of each frame is PAL_EXTRA clocks longer than the other lines.
- R4: An interlaced frame has 525 lines (625 lines when `stdSel` is 1). A progressive frame has 262 lines (312 lines when `stdSel` is 1). Line numbers run from 1 to the last line and then return to 1.
- R5: `hSync` is high for the first HSYNC_W clocks of every line.
- R6: Each line is split into two halves. The first half is floor(length/2) clocks long. The half-lines are counted from the start of the field, where index = 2*(line-1) plus 1 in the second half. `vSync` is high during half-line indices 6 to 11 of a field and low everywhere else.
- R7: In field half-line indices 0 to 5 and 12 to 17, `compSync` is high only for the first EQ_W clocks of each half-line.
- R8: In field half-line indices 6 to 11, `compSync` is high for each half-line except its last SER_W clocks.
- R9: Outside field half-line indices 0 to 17, `compSync` equals `hSync`.
- R10: In an interlaced frame, the second field starts at frame half-line index F, where F is the frame line count. This is the middle of line (F+1)/2. A progressive frame has only the field that starts at line 1.
- R11: `vBlankN` is low for the first 2*VBLANK_LINES half-lines of each field and high otherwise.
- R12: `hBlank` is high while the pixel number is below HBLANK_W.
- R13: A change of `stdSel` or `interlaceSel` takes effect only on the clock edge at which the last pixel of the last line wraps to line 1, pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Four-times-subcarrier clock |
| rst | input | 1 | Synchronous reset, active high |
| stdSel | input | 2 | Standard: 0 NTSC, 1 PAL, 2 PAL-M, 3 NTSC |
| interlaceSel | input | 1 | 1 interlaced, 0 progressive |
| hSync | output | 1 | Horizontal sync pulse, active high |
| vSync | output | 1 | Vertical sync interval, active high |
| compSync | output | 1 | Composite sync with equalizing and serrated pulses, active high |
| vBlankN | output | 1 | Vertical blanking, active low |
| hBlank | output | 1 | Horizontal blanking, active high |
| lineNum | output | 10 | Current line, 1-based |
| pixelNum | output | PIX_W | Current clock within the line, 0-based |

## Verification
Several events can fall in the same cycle. A frame wrap can coincide with a pending change of standard: the line length, the last-line number and the PAL extra clocks all switch on the very edge where the counters return to line 1. The bench changes the selects in mid-frame and compares every output on every clock against a behavioural model that latches the selects only at its own wrap. In the interlaced second field, the vertical interval opens at the midpoint of a line, in the same cycle as a half-line boundary. That case is judged by comparing the composite sync and vertical sync against the model's half-line arithmetic on odd and even line lengths.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  typedef enum logic [1:0] {
    STD_NTSC = 2'd0,
    STD_PAL  = 2'd1,
    STD_PALM = 2'd2,
    STD_ALT  = 2'd3
  } vidStd_e;

  // strobes from the control to the counter datapath
  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
  } cntStrobe_t;

  localparam int LINE_W        = 10;
  localparam int LINES_525     = 525;
  localparam int LINES_625     = 625;
  localparam int EQ_HALVES     = 6;   // three lines of half-line pulses
  localparam int VS_HALVES     = 6;   // three lines of broad pulses
  localparam int VREG_HALVES   = 2 * EQ_HALVES + VS_HALVES;

endpackage

// File: rtl/vsg_counters.sv
module vsg_counters
  import vsg_pkg::*;
#(
  parameter int PIX_W = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  vidStd_e             stdSel,
  input  logic                interlaceSel,
  input  cntStrobe_t          strobe,
  output logic [PIX_W-1:0]    pixel,
  output logic [LINE_W-1:0]   line,
  output vidStd_e             curStd,
  output logic                curIl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pixel  <= '0;
      line   <= LINE_W'(1);
      curStd <= stdSel;
      curIl  <= interlaceSel;
    end else if (strobe.frameEnd) begin
      pixel  <= '0;
      line   <= LINE_W'(1);
      curStd <= stdSel;
      curIl  <= interlaceSel;
    end else if (strobe.lineEnd) begin
      pixel  <= '0;
      line   <= line + 1'b1;
    end else begin
      pixel  <= pixel + 1'b1;
    end
  end

  AST_FRAME_IMPLIES_LINE: assert property (@(posedge clk) disable iff (rst)
    strobe.frameEnd |-> strobe.lineEnd) else $error("frame end without line end"); // R4

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.frameEnd |=> ($stable(curStd) && $stable(curIl))) else $error("mode changed mid-frame"); // R13

endmodule

// File: rtl/vsg_ctrl.sv
module vsg_ctrl
  import vsg_pkg::*;
#(
  parameter int PIX_W     = 11,
  parameter int NTSC_CLKS = 910,
  parameter int PAL_CLKS  = 1135,
  parameter int PALM_CLKS = 909,
  parameter int PAL_EXTRA = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PIX_W-1:0]    pixel,
  input  logic [LINE_W-1:0]   line,
  input  vidStd_e             curStd,
  input  logic                curIl,
  output cntStrobe_t          strobe,
  output logic [PIX_W-1:0]    lineLen,
  output logic [LINE_W-1:0]   frameLines
);

  logic [PIX_W-1:0]  baseLen;
  logic [LINE_W-1:0] lastLine;
  logic              isPal;

  always_comb begin
    unique case (curStd)
      STD_PAL:  baseLen = PIX_W'(PAL_CLKS);
      STD_PALM: baseLen = PIX_W'(PALM_CLKS);
      default:  baseLen = PIX_W'(NTSC_CLKS);
    endcase
    isPal      = (curStd == STD_PAL);
    frameLines = isPal ? LINE_W'(LINES_625) : LINE_W'(LINES_525);
    lastLine   = curIl ? frameLines : ((frameLines - LINE_W'(1)) >> 1);
    lineLen    = (isPal && line == lastLine) ? baseLen + PIX_W'(PAL_EXTRA) : baseLen;
    strobe.lineEnd  = (pixel == lineLen - PIX_W'(1));
    strobe.frameEnd = strobe.lineEnd && (line == lastLine);
  end

  AST_PIXEL_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    pixel < lineLen) else $error("pixel beyond line length"); // R2

  AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (line >= LINE_W'(1)) && (line <= lastLine)) else $error("line outside frame"); // R4

endmodule

// File: rtl/vsg_pulse.sv
module vsg_pulse
  import vsg_pkg::*;
#(
  parameter int PIX_W        = 11,
  parameter int HSYNC_W      = 67,
  parameter int EQ_W         = 33,
  parameter int SER_W        = 67,
  parameter int HBLANK_W     = 156,
  parameter int VBLANK_LINES = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PIX_W-1:0]    pixel,
  input  logic [LINE_W-1:0]   line,
  input  logic [PIX_W-1:0]    lineLen,
  input  logic [LINE_W-1:0]   frameLines,
  input  logic                curIl,
  output logic                hSync,
  output logic                vSync,
  output logic                compSync,
  output logic                vBlankN,
  output logic                hBlank
);

  localparam int VBL_HALVES = 2 * VBLANK_LINES;

  int   pixI, lenI, half0, hsel, hp, hLen, hl, nI, off;
  logic inA, inB, inReg, blankA, blankB;

  always_comb begin
    pixI  = int'(pixel);
    lenI  = int'(lineLen);
    nI    = int'(frameLines);
    half0 = lenI / 2;
    if (pixI < half0) begin
      hsel = 0;
      hp   = pixI;
      hLen = half0;
    end else begin
      hsel = 1;
      hp   = pixI - half0;
      hLen = lenI - half0;
    end
    hl     = 2 * (int'(line) - 1) + hsel;
    inA    = (hl < VREG_HALVES);
    inB    = curIl && (hl >= nI) && (hl < nI + VREG_HALVES);
    inReg  = inA || inB;
    off    = inA ? hl : hl - nI;
    blankA = (hl < VBL_HALVES);
    blankB = curIl && (hl >= nI) && (hl < nI + VBL_HALVES);

    hSync    = (pixI < HSYNC_W);
    vSync    = inReg && (off >= EQ_HALVES) && (off < EQ_HALVES + VS_HALVES);
    if (vSync)       compSync = (hp < hLen - SER_W);
    else if (inReg)  compSync = (hp < EQ_W);
    else             compSync = hSync;
    vBlankN  = !(blankA || blankB);
    hBlank   = (pixI < HBLANK_W);
  end

  AST_HSYNC_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
    (pixel == '0) |-> hSync) else $error("no sync at line start"); // R5

  AST_VSYNC_BLANKED: assert property (@(posedge clk) disable iff (rst)
    vSync |-> !vBlankN) else $error("vertical sync outside blanking"); // R11

  AST_BROAD_OPENS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(vSync) |-> compSync) else $error("broad pulse not high at start"); // R8

endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen
  import vsg_pkg::*;
#(
  parameter int NTSC_CLKS    = 910,
  parameter int PAL_CLKS     = 1135,
  parameter int PALM_CLKS    = 909,
  parameter int PAL_EXTRA    = 2,
  parameter int HSYNC_W      = 67,
  parameter int EQ_W         = 33,
  parameter int SER_W        = 67,
  parameter int HBLANK_W     = 156,
  parameter int VBLANK_LINES = 20,
  localparam int MAX_BASE    = (PAL_CLKS > NTSC_CLKS)
                               ? ((PAL_CLKS > PALM_CLKS) ? PAL_CLKS : PALM_CLKS)
                               : ((NTSC_CLKS > PALM_CLKS) ? NTSC_CLKS : PALM_CLKS),
  localparam int PIX_W       = $clog2(MAX_BASE + PAL_EXTRA + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        stdSel,
  input  logic              interlaceSel,
  output logic              hSync,
  output logic              vSync,
  output logic              compSync,
  output logic              vBlankN,
  output logic              hBlank,
  output logic [9:0]        lineNum,
  output logic [PIX_W-1:0]  pixelNum
);

  cntStrobe_t         strobe;
  logic [PIX_W-1:0]   pixel, lineLen;
  logic [LINE_W-1:0]  line, frameLines;
  vidStd_e            curStd;
  logic               curIl;

  vsg_counters #(.PIX_W(PIX_W)) uCnt (
    .clk(clk), .rst(rst), .stdSel(vidStd_e'(stdSel)), .interlaceSel(interlaceSel),
    .strobe(strobe), .pixel(pixel), .line(line), .curStd(curStd), .curIl(curIl)
  );

  vsg_ctrl #(
    .PIX_W(PIX_W), .NTSC_CLKS(NTSC_CLKS), .PAL_CLKS(PAL_CLKS),
    .PALM_CLKS(PALM_CLKS), .PAL_EXTRA(PAL_EXTRA)
  ) uCtrl (
    .clk(clk), .rst(rst), .pixel(pixel), .line(line), .curStd(curStd), .curIl(curIl),
    .strobe(strobe), .lineLen(lineLen), .frameLines(frameLines)
  );

  vsg_pulse #(
    .PIX_W(PIX_W), .HSYNC_W(HSYNC_W), .EQ_W(EQ_W), .SER_W(SER_W),
    .HBLANK_W(HBLANK_W), .VBLANK_LINES(VBLANK_LINES)
  ) uPulse (
    .clk(clk), .rst(rst), .pixel(pixel), .line(line), .lineLen(lineLen),
    .frameLines(frameLines), .curIl(curIl), .hSync(hSync), .vSync(vSync),
    .compSync(compSync), .vBlankN(vBlankN), .hBlank(hBlank)
  );

  assign lineNum  = line;
  assign pixelNum = pixel;

endmodule

// File: tb/tb_video_sync_gen.sv
module tb_video_sync_gen;

  localparam int CLK_PERIOD = 10;
  localparam int T_NTSC = 40;
  localparam int T_PAL  = 50;
  localparam int T_PALM = 39;
  localparam int T_XTRA = 2;
  localparam int T_HSW  = 4;
  localparam int T_EQW  = 2;
  localparam int T_SERW = 4;
  localparam int T_HBW  = 8;
  localparam int T_VBL  = 20;
  localparam int PW     = $clog2(T_PAL + T_XTRA + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] stdSel = 2'd0;
  logic interlaceSel = 1'b1;
  logic hSync, vSync, compSync, vBlankN, hBlank;
  logic [9:0] lineNum;
  logic [PW-1:0] pixelNum;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  video_sync_gen #(
    .NTSC_CLKS(T_NTSC), .PAL_CLKS(T_PAL), .PALM_CLKS(T_PALM), .PAL_EXTRA(T_XTRA),
    .HSYNC_W(T_HSW), .EQ_W(T_EQW), .SER_W(T_SERW), .HBLANK_W(T_HBW), .VBLANK_LINES(T_VBL)
  ) dut (
    .clk(clk), .rst(rst), .stdSel(stdSel), .interlaceSel(interlaceSel),
    .hSync(hSync), .vSync(vSync), .compSync(compSync), .vBlankN(vBlankN),
    .hBlank(hBlank), .lineNum(lineNum), .pixelNum(pixelNum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int normStd(int s);
    return (s == 3) ? 0 : s;
  endfunction

  function automatic int framesLines(int s);
    return (s == 1) ? 625 : 525;
  endfunction

  function automatic int lastOf(int s, int il);
    return il ? framesLines(s) : (framesLines(s) - 1) / 2;
  endfunction

  function automatic int lenOf(int s, int ln, int il);
    int base;
    base = (s == 1) ? T_PAL : (s == 2) ? T_PALM : T_NTSC;
    if (s == 1 && ln == lastOf(s, il)) base += T_XTRA;
    return base;
  endfunction

  // behavioural reference state
  int mLine, mPix, mStd, mIl;
  bit mValid = 0;

  always @(posedge clk) begin
    if (rst) begin
      mLine = 1; mPix = 0; mStd = normStd(int'(stdSel)); mIl = int'(interlaceSel); mValid = 1;
    end else if (mValid) begin
      if (mPix == lenOf(mStd, mLine, mIl) - 1) begin
        mPix = 0;
        if (mLine == lastOf(mStd, mIl)) begin
          mLine = 1; mStd = normStd(int'(stdSel)); mIl = int'(interlaceSel);
        end else mLine++;
      end else mPix++;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (line %0d pixel %0d std %0d il %0d)",
               req, what, act, exp, mLine, mPix, mStd, mIl);
    end
  endtask

  always @(negedge clk) begin
    if (mValid && !finished) begin
      int len, half, hsel, hp, hLen, hl, fh, n;
      bit vz, eVs, eCs, eHs;
      n    = framesLines(mStd);
      len  = lenOf(mStd, mLine, mIl);
      half = len / 2;
      hsel = (mPix >= half) ? 1 : 0;
      hp   = hsel ? mPix - half : mPix;
      hLen = hsel ? len - half : half;
      hl   = 2 * (mLine - 1) + hsel;
      fh   = (mIl && hl >= n) ? hl - n : hl;
      vz   = fh < 18;
      eHs  = mPix < T_HSW;
      eVs  = vz && fh >= 6 && fh < 12;
      eCs  = eVs ? (hp < hLen - T_SERW) : vz ? (hp < T_EQW) : eHs;
      chk((mStd == 1 && mLine == lastOf(mStd, mIl)) ? "R3" : "R2", "pixelNum", int'(pixelNum), mPix);
      chk((normStd(int'(stdSel)) != mStd || int'(interlaceSel) != mIl) ? "R13" : "R4",
          "lineNum", int'(lineNum), mLine);
      chk("R5", "hSync", int'(hSync), int'(eHs));
      chk((mIl && hl >= n) ? "R10" : "R6", "vSync", int'(vSync), int'(eVs));
      chk(eVs ? "R8" : vz ? "R7" : "R9", "compSync", int'(compSync), int'(eCs));
      chk("R11", "vBlankN", int'(vBlankN), int'(!(fh < 2 * T_VBL)));
      chk("R12", "hBlank", int'(hBlank), int'(mPix < T_HBW));
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (errors > 40) finish_run();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: one edge after reset release the counters have moved one pixel from line 1, pixel 0
    chk("R1", "lineNum after reset", int'(lineNum), 1);
    chk("R1", "pixelNum after reset", int'(pixelNum), 1);
    run(5000);
    stdSel = 2'd1; interlaceSel = 1'b1;           // pending until NTSC frame wraps (R13)
    run(20000);
    stdSel = 2'd2; interlaceSel = 1'b0;           // PAL-M progressive after PAL frame
    run(40000);
    stdSel = 2'd3; interlaceSel = 1'b0;           // code 3 acts as NTSC
    run(15000);
    stdSel = 2'd1; interlaceSel = 1'b0;           // PAL progressive with extra-clock last line
    run(25000);
    rst = 1'b1; stdSel = 2'd2; interlaceSel = 1'b1;
    run(2);
    rst = 1'b0;
    // R1: the mid-run reset restarts the raster
    chk("R1", "lineNum after mid reset", int'(lineNum), 1);
    chk("R1", "pixelNum after mid reset", int'(pixelNum), 0);
    run(45000);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule